// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a countdown timer that sits on a simple synchronous register bus. Software programs a 32-bit period through two 16-bit registers and sets the mode bits in a control register. The block then counts down from the period. When the count reaches zero it raises a timeout flag and, if enabled, an interrupt request. In continuous mode the counter reloads and keeps going. In one-shot mode it halts after the first timeout. Software acknowledges the event by writing anything to the status register.

Two build-time switches change how the period registers behave. The first decides whether the period can be rewritten or stays fixed at the build-time value; in the fixed build, a write to a period half only restarts the count from that value. The second decides whether start and stop control exists. Without it, the counter runs from reset and never halts on a bus write. With it, a write to a period half also stops the counter. Bus reads are combinational from the address. Writes take effect at the clock edge on which the write enable is sampled high.

Top module: `ivl_timer`

## Requirements
- R1: Word address 0 is status (bit 0 timeout flag, bit 1 running), 1 is control (bit 0 interrupt enable, bit 1 continuous, bit 2 start, bit 3 stop), 2 is the low period half and 3 the high period half. Start and stop are write-only and read as zero, as do all other unused bits.
- R2: After reset in the start/stop build, the counter is stopped and holds the default period. Status and control read zero, the period halves read the default period, and the interrupt is low.
- R3: A counter started with period P sets the timeout flag on the (P+1)-th clock edge after the edge that wrote the start bit.
- R4: In continuous mode the counter reloads the period at the timeout and times out again every P+1 edges while running stays set. In one-shot mode running clears at the timeout and no further timeout follows.
- R5: A write of any value to status clears the timeout flag and so the interrupt. Without that write the flag stays set.
- R6: A timeout on the same edge as a status write leaves the flag set.
- R7: The interrupt output is high exactly while both the timeout flag and the interrupt enable bit are set.
- R8: Writing the start bit to a running counter neither restarts nor reloads the count.
- R9: Writing the stop bit halts the counter. When start and stop are written together, the counter ends up stopped.
- R10: In the writable start/stop build, a write to a period half replaces only that 16-bit half, reads back, loads the counter with the new 32-bit period and stops the counter.
- R11: In the fixed-period build without start/stop control, the counter runs from reset. A write to either period half leaves the period at its build-time value, reloads the counter with it and leaves it running, which also restarts a counter halted by one-shot mode. Start and stop bits have no effect and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Word address of the register |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The bench places a status clear on the exact edge of a timeout. A design that lets the clear win loses an event there. The bench rewrites the start bit midway through a count, which catches a design that reloads on every start by moving the next timeout late. It writes start and stop together, and a period half while counting, and expects a stopped counter that stays silent afterwards. A design with the wrong priority or no stop side effect would go on to time out. A second instance built with a fixed period and no start/stop control checks that a period write restarts a halted one-shot count with the build value, keeps the counter running, and ignores the stop bit. A design that took the written data or honoured stop would miss the expected timeout edge.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_PLO  = 2'd2,
    REG_PHI  = 2'd3
  } reg_sel_e;

  // status field positions
  localparam int unsigned ST_TIMEOUT = 0;
  localparam int unsigned ST_RUN     = 1;

  // control field positions
  localparam int unsigned CT_IRQEN = 0;
  localparam int unsigned CT_CONT  = 1;
  localparam int unsigned CT_GO    = 2;
  localparam int unsigned CT_HALT  = 3;

endpackage

// File: rtl/ivl_timer_rstsync.sv
module ivl_timer_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
  import ivl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [2*DATA_W-1:0] DEF_PERIOD = '0,
  parameter bit PERIOD_WRITABLE = 1'b1,
  parameter bit HAS_STARTSTOP   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            addr,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  timeout,
  input  logic                  running,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  wr_stat,
  output logic                  start_req,
  output logic                  stop_req,
  output logic                  load_req,
  output logic                  irq_en,
  output logic                  cont,
  output logic [2*DATA_W-1:0]   period_cur,
  output logic [2*DATA_W-1:0]   period_new
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  reg_sel_e sel;
  logic     wr_ctrl;
  logic     wr_plo;
  logic     wr_phi;

  assign sel     = reg_sel_e'(addr);
  assign wr_stat = wr_en && (sel == REG_STAT);
  assign wr_ctrl = wr_en && (sel == REG_CTRL);
  assign wr_plo  = wr_en && (sel == REG_PLO);
  assign wr_phi  = wr_en && (sel == REG_PHI);
  assign load_req = wr_plo | wr_phi;

  // mode bits
  logic irq_en_q, irq_en_d;
  logic cont_q, cont_d;
  logic ctrl_en;

  assign ctrl_en = wr_ctrl;

  always_comb begin
    irq_en_d = wr_data[CT_IRQEN];
    cont_d   = wr_data[CT_CONT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      cont_q   <= 1'b0;
    end else if (ctrl_en) begin
      irq_en_q <= irq_en_d;
      cont_q   <= cont_d;
    end
  end

  assign irq_en = irq_en_q;
  assign cont   = cont_q;

  // start / stop requests
  generate
    if (HAS_STARTSTOP) begin : g_ss
      assign start_req = wr_ctrl & wr_data[CT_GO];
      assign stop_req  = wr_ctrl & wr_data[CT_HALT];
    end else begin : g_no_ss
      assign start_req = 1'b0;
      assign stop_req  = 1'b0;
    end
  endgenerate

  // period storage
  generate
    if (PERIOD_WRITABLE) begin : g_pwr
      logic [CNT_W-1:0] period_q;
      logic [CNT_W-1:0] period_d;
      logic             period_en;

      assign period_en = load_req;

      always_comb begin
        period_d = period_q;
        if (wr_plo) period_d[DATA_W-1:0]     = wr_data;
        if (wr_phi) period_d[CNT_W-1:DATA_W] = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          period_q <= DEF_PERIOD;
        end else if (period_en) begin
          period_q <= period_d;
        end
      end

      assign period_cur = period_q;
      assign period_new = period_d;
    end else begin : g_pfix
      assign period_cur = DEF_PERIOD;
      assign period_new = DEF_PERIOD;
    end
  endgenerate

  // read mux
  always_comb begin
    rd_data = '0;
    case (sel)
      REG_STAT: begin
        rd_data[ST_TIMEOUT] = timeout;
        rd_data[ST_RUN]     = running;
      end
      REG_CTRL: begin
        rd_data[CT_IRQEN] = irq_en_q;
        rd_data[CT_CONT]  = cont_q;
      end
      REG_PLO: rd_data = period_cur[DATA_W-1:0];
      REG_PHI: rd_data = period_cur[CNT_W-1:DATA_W];
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ivl_timer_count.sv
module ivl_timer_count #(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_CNT = '0,
  parameter bit HAS_STARTSTOP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             load_req,
  input  logic             cont,
  input  logic [CNT_W-1:0] period_cur,
  input  logic [CNT_W-1:0] period_new,
  output logic             running,
  output logic             zero_evt
);

  localparam bit RUN_AT_RESET = !HAS_STARTSTOP;
  localparam bit RUN_AFTER_LOAD = !HAS_STARTSTOP;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    zero_evt = 1'b0;
    if (load_req) begin
      cnt_d = period_new;
      run_d = RUN_AFTER_LOAD;
    end else if (stop_req) begin
      run_d = 1'b0;
    end else if (start_req && !run_q) begin
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        zero_evt = 1'b1;
        cnt_d    = period_cur;
        if (!cont) run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_en = load_req | (run_q & ~stop_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_CNT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= RUN_AT_RESET;
    end else begin
      run_q <= run_d;
    end
  end

  assign running = run_q;

endmodule

// File: rtl/ivl_timer_flag.sv
module ivl_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic wr_stat,
  input  logic irq_en,
  output logic timeout,
  output logic irq
);

  logic to_q, to_d;
  logic to_en;

  assign to_en = zero_evt | wr_stat;

  always_comb begin
    // a fresh event outranks an acknowledge on the same edge
    to_d = zero_evt ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b0;
    end else if (to_en) begin
      to_q <= to_d;
    end
  end

  assign timeout = to_q;
  assign irq     = to_q & irq_en;

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned DEFAULT_PERIOD  = 1000,
  parameter bit          PERIOD_WRITABLE = 1'b1,
  parameter bit          HAS_STARTSTOP   = 1'b1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int unsigned      CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEFAULT_PERIOD);

  logic             rst_q_n;
  logic             wr_stat;
  logic             start_req;
  logic             stop_req;
  logic             load_req;
  logic             irq_en;
  logic             ctrl_cont;
  logic [CNT_W-1:0] period_cur;
  logic [CNT_W-1:0] period_new;
  logic             running;
  logic             zero_evt;
  logic             timeout;

  ivl_timer_rstsync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_q_n)
  );

  ivl_timer_regs #(
    .DATA_W          (DATA_W),
    .DEF_PERIOD      (DEF_P),
    .PERIOD_WRITABLE (PERIOD_WRITABLE),
    .HAS_STARTSTOP   (HAS_STARTSTOP)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .timeout    (timeout),
    .running    (running),
    .rd_data    (rd_data),
    .wr_stat    (wr_stat),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .load_req   (load_req),
    .irq_en     (irq_en),
    .cont       (ctrl_cont),
    .period_cur (period_cur),
    .period_new (period_new)
  );

  ivl_timer_count #(
    .CNT_W         (CNT_W),
    .RST_CNT       (DEF_P),
    .HAS_STARTSTOP (HAS_STARTSTOP)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .load_req   (load_req),
    .cont       (ctrl_cont),
    .period_cur (period_cur),
    .period_new (period_new),
    .running    (running),
    .zero_evt   (zero_evt)
  );

  ivl_timer_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .zero_evt (zero_evt),
    .wr_stat  (wr_stat),
    .irq_en   (irq_en),
    .timeout  (timeout),
    .irq      (irq)
  );

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
  import ivl_timer_pkg::*;
#(
  parameter bit HAS_STARTSTOP = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       ctl_halt,
  input logic       irq,
  input logic       running,
  input logic       timeout,
  input logic       cont,
  input logic       zero_evt
);

  logic stat_wr;
  assign stat_wr = wr_en && (addr == REG_STAT);

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !zero_evt) |=> !irq); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !stat_wr) |=> timeout); // R5

  AST_ZERO_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> timeout); // R6

  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !cont) |=> !running); // R4

  generate
    if (HAS_STARTSTOP) begin : g_ss_chk
      AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL && ctl_halt) |=> !running); // R9

      AST_PERIOD_WR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1]) |=> !running); // R10
    end
  endgenerate

endmodule

bind ivl_timer ivl_timer_chk #(.HAS_STARTSTOP(HAS_STARTSTOP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .ctl_halt (wr_data[ivl_timer_pkg::CT_HALT]),
  .irq      (irq),
  .running  (running),
  .timeout  (timeout),
  .cont     (ctrl_cont),
  .zero_evt (zero_evt)
);

// File: tb/test_ivl_timer.sv
module test_ivl_timer;

  localparam int CLK_P  = 40;
  localparam int DW     = 16;
  localparam int WD_MAX = 20000;

  logic clk;
  logic arst_n;

  logic [1:0]    m_addr, f_addr;
  logic          m_we, f_we;
  logic [DW-1:0] m_wd, f_wd;
  logic [DW-1:0] m_rd, f_rd;
  logic          m_irq, f_irq;

  int checks;
  int errors;
  bit done;

  typedef struct {
    int            unit;   // 0 main, 1 fixed
    bit            is_irq;
    logic [DW-1:0] exp;
    string         tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;

  ivl_timer #(
    .DATA_W(DW), .DEFAULT_PERIOD(20), .PERIOD_WRITABLE(1'b1), .HAS_STARTSTOP(1'b1)
  ) i_ivl_timer (
    .clk(clk), .arst_n(arst_n), .addr(m_addr), .wr_en(m_we),
    .wr_data(m_wd), .rd_data(m_rd), .irq(m_irq)
  );

  ivl_timer #(
    .DATA_W(DW), .DEFAULT_PERIOD(7), .PERIOD_WRITABLE(1'b0), .HAS_STARTSTOP(1'b0)
  ) i_ivl_timer_fixed (
    .clk(clk), .arst_n(arst_n), .addr(f_addr), .wr_en(f_we),
    .wr_data(f_wd), .rd_data(f_rd), .irq(f_irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [DW-1:0] act;
        it = sb_q.pop_front();
        if (it.is_irq) act = DW'((it.unit == 0) ? m_irq : f_irq);
        else           act = (it.unit == 0) ? m_rd : f_rd;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int unit, input logic [1:0] a, input logic [DW-1:0] d);
    if (unit == 0) begin m_addr = a; m_wd = d; m_we = 1'b1; end
    else           begin f_addr = a; f_wd = d; f_we = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    m_we = 1'b0;
    f_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_rd(input int unit, input logic [1:0] a, input logic [DW-1:0] e, input string tag);
    sb_item_t it;
    if (unit == 0) m_addr = a; else f_addr = a;
    #1;
    it.unit = unit; it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic exp_irq(input int unit, input logic e, input string tag);
    sb_item_t it;
    #1;
    it.unit = unit; it.is_irq = 1'b1; it.exp = DW'(e); it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_MAX) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    arst_n = 1'b0;
    m_addr = '0; m_we = 1'b0; m_wd = '0;
    f_addr = '0; f_we = 1'b0; f_wd = '0;
    idle(3);
    arst_n = 1'b1;
    idle(3);

    // R2 reset state, R1 map
    exp_rd(0, 2'd0, 16'h0000, "R2 status after reset");
    exp_rd(0, 2'd1, 16'h0000, "R2 control after reset");
    exp_rd(0, 2'd2, 16'd20,   "R2 period low default");
    exp_rd(0, 2'd3, 16'h0000, "R2 period high default");
    exp_irq(0, 1'b0,          "R2 irq low");
    exp_rd(1, 2'd0, 16'h0002, "R11 fixed build runs from reset");
    idle(1);

    // R10 halves stored separately
    wr(0, 2'd2, 16'd5);
    wr(0, 2'd3, 16'h00AB);
    exp_rd(0, 2'd2, 16'd5,    "R10 low half readback");
    exp_rd(0, 2'd3, 16'h00AB, "R10 high half readback");
    wr(0, 2'd3, 16'h0000);
    exp_rd(0, 2'd3, 16'h0000, "R10 high half rewritten");
    exp_rd(0, 2'd2, 16'd5,    "R10 low half untouched");

    // R3 first timeout, continuous with irq enabled
    wr(0, 2'd1, 16'h0007);
    idle(5);
    exp_rd(0, 2'd0, 16'h0002, "R3 no timeout before P+1");
    idle(1);
    exp_rd(0, 2'd0, 16'h0003, "R3 timeout at P+1");
    exp_irq(0, 1'b1,          "R7 irq with flag and enable");
    exp_rd(0, 2'd1, 16'h0003, "R1 start bit reads zero");

    // R5 clear
    wr(0, 2'd0, 16'hFFFF);
    exp_rd(0, 2'd0, 16'h0002, "R5 status write clears flag");
    exp_irq(0, 1'b0,          "R5 irq cleared");
    idle(4);
    exp_rd(0, 2'd0, 16'h0002, "R4 reload not yet expired");
    idle(1);
    exp_rd(0, 2'd0, 16'h0003, "R4 continuous reload interval");

    // R6 clear on the timeout edge
    idle(5);
    wr(0, 2'd0, 16'h0000);
    exp_rd(0, 2'd0, 16'h0003, "R6 timeout wins over clear");

    // R8 start while running
    wr(0, 2'd0, 16'h0000);
    exp_rd(0, 2'd0, 16'h0002, "R8 cleared before restart attempt");
    wr(0, 2'd1, 16'h0007);
    idle(3);
    exp_rd(0, 2'd0, 16'h0002, "R8 count not restarted (early)");
    idle(1);
    exp_rd(0, 2'd0, 16'h0003, "R8 timeout on original schedule");

    // R7 mask
    wr(0, 2'd1, 16'h0006);
    exp_irq(0, 1'b0,          "R7 irq masked by enable");
    exp_rd(0, 2'd0, 16'h0003, "R7 flag kept while masked");
    wr(0, 2'd1, 16'h0007);
    exp_irq(0, 1'b1,          "R7 irq unmasked");

    // R9 start and stop together
    wr(0, 2'd1, 16'h000F);
    exp_rd(0, 2'd0, 16'h0001, "R9 start with stop leaves counter stopped");
    idle(10);
    wr(0, 2'd0, 16'h0000);
    idle(10);
    exp_rd(0, 2'd0, 16'h0000, "R9 no timeout while stopped");

    // R4 one-shot
    wr(0, 2'd2, 16'd3);
    exp_rd(0, 2'd0, 16'h0000, "R10 period write keeps counter stopped");
    wr(0, 2'd1, 16'h0005);
    idle(3);
    exp_rd(0, 2'd0, 16'h0002, "R4 one-shot counting");
    idle(1);
    exp_rd(0, 2'd0, 16'h0001, "R4 one-shot halts at timeout");
    exp_irq(0, 1'b1,          "R7 one-shot irq");
    idle(10);
    wr(0, 2'd0, 16'h0000);
    idle(10);
    exp_rd(0, 2'd0, 16'h0000, "R4 one-shot no further timeout");

    // R10 period write stops a running counter
    wr(0, 2'd1, 16'h0007);
    idle(2);
    exp_rd(0, 2'd0, 16'h0002, "R10 running before period write");
    wr(0, 2'd3, 16'h0000);
    exp_rd(0, 2'd0, 16'h0000, "R10 period write stops counter");
    idle(10);
    exp_rd(0, 2'd0, 16'h0000, "R10 stopped counter stays silent");

    // R11 fixed-period build without start/stop
    exp_rd(1, 2'd0, 16'h0001, "R11 one-shot halt after first timeout");
    wr(1, 2'd0, 16'h0000);
    exp_rd(1, 2'd0, 16'h0000, "R11 flag cleared");
    wr(1, 2'd1, 16'h000A);
    exp_rd(1, 2'd0, 16'h0000, "R11 control write does not start");
    wr(1, 2'd2, 16'h1234);
    exp_rd(1, 2'd0, 16'h0002, "R11 period write restarts counter");
    exp_rd(1, 2'd2, 16'd7,    "R11 period low stays fixed");
    exp_rd(1, 2'd3, 16'h0000, "R11 period high stays fixed");
    exp_rd(1, 2'd1, 16'h0002, "R11 stop bit absent, reads zero");
    idle(7);
    exp_rd(1, 2'd0, 16'h0002, "R11 fixed reload not yet expired");
    idle(1);
    exp_rd(1, 2'd0, 16'h0003, "R11 timeout after fixed period, still running");
    exp_irq(1, 1'b0,          "R7 fixed build irq disabled");

    idle(2);
    done = 1'b1;
    finish_run();
  end

endmodule